// File: doc/BRIEF.md
# PHY Event Statistics and Interrupt Unit

This block keeps the event statistics of a 10/100 Ethernet physical layer and raises its interrupt. It takes single-cycle event strobes from the receive and link logic. It accumulates three 16-bit counts: losses of link, false-carrier starts, and packets received with errors. It also collects interrupt causes in a sticky status register, which is gated by a per-source enable vector.

Management logic reads a register by pulsing a read strobe with a 2-bit address. The value held before the read appears on the read data bus one cycle later. The register that was read is cleared at the same clock edge. Each event counter follows its own overflow policy. A status bit gives early warning when the top bit of the false-carrier count or the receive-error count becomes set, so software can read the count before it saturates or wraps.

Top module: `phy_evt_stats`

## Requirements
- R1: After reset, all three counts and the status register are zero, `rd_data` is zero and `irq` is low.
- R2: A read strobe at address 0 (link-loss count), 1 (false-carrier count), 2 (receive-error count) or 3 (status, bits 4:0, upper bits zero) puts the value held before that edge on `rd_data` one cycle later. `rd_data` holds that value until the next read.
- R3: The link-loss count adds one for each cycle `ev_link_lost` is high and wraps from FFFFh to 0000h.
- R4: The false-carrier count adds one for each cycle `ev_bad_ssd` is high and stays at FFFFh once it gets there.
- R5: The receive-error count adds one only in a cycle where `ev_pkt_end` and `ev_pkt_err` are high and `ev_pkt_col` is low. It wraps from FFFFh to 0000h.
- R6: Reading a count clears it to zero. If that count's event arrives in the same cycle as the read, the count becomes 1.
- R7: The status bits are sticky. Bit 0 records a link change, bit 1 records jabber, bit 2 records a received page, bit 3 records that the false-carrier count's top bit has become set, and bit 4 records the same for the receive-error count.
- R8: Reading the status register clears it. A source that fires in the same cycle as the read leaves its bit set.
- R9: `irq` is high exactly when some status bit i is set and `irq_en[i]` is high.
- R10: Bits 3 and 4 set only on a 0-to-1 change of the count's top bit. After they are cleared, they do not set again while the top bit merely stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_link_lost | input | 1 | Link-OK lost strobe |
| ev_bad_ssd | input | 1 | End of a malformed start-of-stream event |
| ev_pkt_end | input | 1 | End of received packet |
| ev_pkt_err | input | 1 | Packet had one or more receive errors |
| ev_pkt_col | input | 1 | Packet errors were caused by a collision |
| ev_link_chg | input | 1 | Link status change strobe |
| ev_jabber | input | 1 | Jabber detected strobe |
| ev_page_rx | input | 1 | Negotiation page received strobe |
| irq_en | input | 5 | Per-source interrupt enables |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register select |
| rd_data | output | 16 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs every event source for 65540 consecutive cycles. In that run the link-loss and receive-error counts wrap to 4, and the false-carrier count stops at FFFFh. A design with the overflow policies swapped, or one missing the saturation check, would read back the wrong values. Reads that coincide with an event check that the count loads 1, and that a coinciding status source survives the status clear. A design that lets the clear win would lose the event. After the warning bits are cleared while the top bit stays high, a further status read must return zero. A level-sensitive warning would set again there. Packets that ended with a collision, or without an error flag, must leave the receive-error count unchanged. A reference model checks the read data and the interrupt line against the design on every cycle.

// File: rtl/phy_evt_stats.sv
module phy_evt_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_link_lost,
  input  logic             ev_bad_ssd,
  input  logic             ev_pkt_end,
  input  logic             ev_pkt_err,
  input  logic             ev_pkt_col,
  input  logic             ev_link_chg,
  input  logic             ev_jabber,
  input  logic             ev_page_rx,
  input  logic [4:0]       irq_en,
  input  logic             rd_stb,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  localparam int NSRC = 5;
  localparam int TOP = CNT_W - 1;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] disc_q, fcar_q, rerr_q;
  logic [CNT_W-1:0] disc_d, fcar_d, rerr_d;
  logic [NSRC-1:0]  sts_q, sts_set;

  wire rd_disc = rd_stb && (rd_addr == 2'd0);
  wire rd_fcar = rd_stb && (rd_addr == 2'd1);
  wire rd_rerr = rd_stb && (rd_addr == 2'd2);
  wire rd_sts  = rd_stb && (rd_addr == 2'd3);
  wire rerr_ev = ev_pkt_end & ev_pkt_err & ~ev_pkt_col;
  wire fcar_inc = ev_bad_ssd && (fcar_q != CMAX);

  always_comb begin
    disc_d = rd_disc ? CNT_W'(ev_link_lost) : disc_q + CNT_W'(ev_link_lost);
    fcar_d = rd_fcar ? CNT_W'(ev_bad_ssd)   : fcar_q + CNT_W'(fcar_inc);
    rerr_d = rd_rerr ? CNT_W'(rerr_ev)      : rerr_q + CNT_W'(rerr_ev);
  end

  assign sts_set = {rerr_d[TOP] & ~rerr_q[TOP], fcar_d[TOP] & ~fcar_q[TOP],
                    ev_page_rx, ev_jabber, ev_link_chg};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disc_q  <= '0;
      fcar_q  <= '0;
      rerr_q  <= '0;
      sts_q   <= '0;
      rd_data <= '0;
    end else begin
      disc_q <= disc_d;
      fcar_q <= fcar_d;
      rerr_q <= rerr_d;
      sts_q  <= (rd_sts ? '0 : sts_q) | sts_set;
      if (rd_stb) begin
        case (rd_addr)
          2'd0:    rd_data <= disc_q;
          2'd1:    rd_data <= fcar_q;
          2'd2:    rd_data <= rerr_q;
          default: rd_data <= {{(CNT_W-NSRC){1'b0}}, sts_q};
        endcase
      end
    end
  end

  assign irq = |(sts_q & irq_en);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_q == CMAX && ev_link_lost && !rd_disc) |=> disc_q == '0);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fcar_q == CMAX && !rd_fcar) |=> fcar_q == CMAX);
  p_col_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pkt_col && !rd_rerr) |=> $stable(rerr_q));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fcar && !ev_bad_ssd) |=> fcar_q == '0);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sts |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
  p_edge_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fcar_q[TOP] && rd_sts && !rd_fcar) |=> !sts_q[3]);
endmodule

// File: tb/phy_evt_stats_tb_top.sv
module phy_evt_stats_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_link_lost = 0, ev_bad_ssd = 0, ev_pkt_end = 0, ev_pkt_err = 0, ev_pkt_col = 0;
  logic ev_link_chg = 0, ev_jabber = 0, ev_page_rx = 0;
  logic [4:0] irq_en = '0;
  logic rd_stb = 0;
  logic [1:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic irq;

  int checks = 0, errors = 0;
  int m_dc = 0, m_fc = 0, m_re = 0, m_sts = 0, m_rd = 0;

  always #4 clk = ~clk;

  phy_evt_stats dut_i (
    .clk(clk), .rst_n(rst_n), .ev_link_lost(ev_link_lost), .ev_bad_ssd(ev_bad_ssd),
    .ev_pkt_end(ev_pkt_end), .ev_pkt_err(ev_pkt_err), .ev_pkt_col(ev_pkt_col),
    .ev_link_chg(ev_link_chg), .ev_jabber(ev_jabber), .ev_page_rx(ev_page_rx),
    .irq_en(irq_en), .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, updated at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_dc = 0; m_fc = 0; m_re = 0; m_sts = 0; m_rd = 0;
    end else begin
      int old_fc, old_re, set;
      bit re_ev;
      old_fc = m_fc; old_re = m_re;
      re_ev = ev_pkt_end && ev_pkt_err && !ev_pkt_col;
      if (rd_stb)
        m_rd = (rd_addr == 0) ? m_dc : (rd_addr == 1) ? m_fc : (rd_addr == 2) ? m_re : m_sts;
      if (rd_stb && rd_addr == 0) m_dc = ev_link_lost;
      else if (ev_link_lost) m_dc = (m_dc + 1) % 65536;
      if (rd_stb && rd_addr == 1) m_fc = ev_bad_ssd;
      else if (ev_bad_ssd && m_fc < 65535) m_fc = m_fc + 1;
      if (rd_stb && rd_addr == 2) m_re = re_ev;
      else if (re_ev) m_re = (m_re + 1) % 65536;
      set = ev_link_chg | (ev_jabber << 1) | (ev_page_rx << 2);
      if (m_fc >= 32768 && old_fc < 32768) set |= 8;
      if (m_re >= 32768 && old_re < 32768) set |= 16;
      m_sts = ((rd_stb && rd_addr == 3) ? 0 : m_sts) | set;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 rd_data vs model", rd_data, m_rd);
      chk("R9 irq vs model", irq, ((m_sts & irq_en) != 0));
    end
  end

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_stb = 1; rd_addr = 2'(a);
    @(negedge clk); rd_stb = 0; v = rd_data;
  endtask

  task automatic tick;
    @(negedge clk);
    {ev_link_lost, ev_bad_ssd, ev_pkt_end, ev_pkt_err, ev_pkt_col, ev_link_chg, ev_jabber, ev_page_rx} = '0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    summary();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    chk("R1 reset rd_data", rd_data, 0);
    chk("R1 reset irq", irq, 0);
    rst_n = 1;
    for (int a = 0; a < 4; a++) begin rd(a, v); chk("R1 reset value", v, 0); end

    // R3 counting
    repeat (3) begin @(negedge clk); ev_link_lost = 1; tick(); end
    rd(0, v); chk("R3 link-loss count", v, 3);
    rd(0, v); chk("R6 cleared after read", v, 0);

    // R5 filter
    @(negedge clk); ev_pkt_end = 1; ev_pkt_err = 1; tick();
    @(negedge clk); ev_pkt_end = 1; ev_pkt_err = 1; ev_pkt_col = 1; tick();
    @(negedge clk); ev_pkt_end = 1; tick();
    @(negedge clk); ev_pkt_err = 1; tick();
    rd(2, v); chk("R5 only error w/o collision counted", v, 1);

    // R6 event in same cycle as read
    @(negedge clk); ev_bad_ssd = 1; tick();
    @(negedge clk); ev_bad_ssd = 1; rd_stb = 1; rd_addr = 2'd1;
    @(negedge clk); ev_bad_ssd = 0; rd_stb = 0; chk("R2 read returns prior value", rd_data, 1);
    rd(1, v); chk("R6 read+event loads 1", v, 1);

    // R7 / R9 status and mask
    @(negedge clk); ev_link_chg = 1; tick();
    @(negedge clk); ev_jabber = 1; ev_page_rx = 1; tick();
    chk("R9 masked irq low", irq, 0);
    irq_en = 5'b00010;
    @(negedge clk); chk("R9 enabled irq high", irq, 1);
    irq_en = 5'b11000;
    @(negedge clk); chk("R9 irq low, enabled bits clear", irq, 0);
    rd(3, v); chk("R7 sticky status", v, 7);
    rd(3, v); chk("R8 status cleared by read", v, 0);

    // R8 source in same cycle as status read
    @(negedge clk); ev_jabber = 1; rd_stb = 1; rd_addr = 2'd3;
    @(negedge clk); ev_jabber = 0; rd_stb = 0;
    rd(3, v); chk("R8 coinciding source kept", v, 2);

    // long run: wrap, saturate, warnings
    irq_en = 5'b11111;
    @(negedge clk); ev_link_lost = 1; ev_bad_ssd = 1; ev_pkt_end = 1; ev_pkt_err = 1;
    repeat (65539) @(negedge clk);
    tick();
    chk("R9 irq from warning", irq, 1);
    rd(0, v); chk("R3 wrap", v, 4);
    rd(2, v); chk("R5 wrap", v, 4);
    rd(3, v); chk("R7 warning bits", v, 'h18);
    repeat (5) begin @(negedge clk); ev_bad_ssd = 1; tick(); end
    rd(3, v); chk("R10 no re-set while top bit high", v, 0);
    rd(1, v); chk("R4 saturation", v, 'hFFFF);
    rd(1, v); chk("R6 saturated count cleared", v, 0);
    chk("R9 irq low after clear", irq, 0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule